// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block steers one disk or optical-drive DMA transfer through a chunked descriptor channel. A start strobe arms it: it latches the drive kind, the command and the starting sector, loads the byte count still owed, clears the running index and raises its active flag. After that, each chunk the channel hands over becomes one block request. The request carries the media byte offset, the length and an operation code. The block then waits for the storage side to report completion.

The sector shift depends on the drive kind. A disk uses 512-byte sectors and an optical drive uses 2048-byte sectors. Optical data that has no block address is copied straight from the internal buffer, and that path completes the command at once. The transfer finishes with a good status byte and an interrupt, or with a failure status. Chunks that arrive before the sequencer is armed, or after it has finished, are dropped. An unsupported disk command sends the sequencer to a fault state, where it raises an error flag and keeps running.

Top module: `ide_dma_seq`

## Requirements
- R1: After reset the sequencer is inactive, with status 0x00 and every pulse output low. A `startReq` loads the remaining count (`sectorCount`×512 for a disk, `packetSize` for an optical drive) and sets the index to zero. One cycle later `chanKick` pulses, `dmaActive` is 1 and `errFlag` is 0. The status byte is left unchanged.
- R2: A `chunkValid` while `dmaActive` is 0 produces no request, no `chanEnd` and no interrupt.
- R3: A chunk that arrives while the remaining count is ≤ 0 completes the transfer. Status becomes 0x50 (ready 0x40 | seek 0x10), `irq` and `chanEnd` pulse, `dmaActive` clears and no request is issued.
- R4: A zero-length chunk pulses only `chanEnd`. `dmaActive` stays 1.
- R5: A disk chunk issues a request at offset (sector << 9) + index with length `chunkLen`. The `reqOp` code follows the command: read 0, write 1, trim 2.
- R6: An optical chunk with a block address issues a read (`reqOp` 0) at offset (LBA << 11) + index.
- R7: An optical chunk with `lbaNone` set issues a copy (`reqOp` 3) at offset 0, with length min(remaining, `chunkLen`). In the same cycle status becomes 0x50, `irq` and `chanEnd` pulse and `dmaActive` clears.
- R8: Each issued chunk lowers the remaining count by its length and raises the index by its length. The remaining count may go negative.
- R9: A good `blkDone` completes the transfer as in R3 if the remaining count is ≤ 0. Otherwise it pulses only `chanEnd` and waits for the next chunk.
- R10: A `blkDone` with `blkErr` sets status 0x41 (ready | error), pulses `irq` and `chanEnd` and clears `dmaActive`. `acctFail` pulses only for a read or write (optical transfers count as reads), never for a trim.
- R11: A disk chunk with command code 3 issues no request and no interrupt. It sets `errFlag` and status 0x41, pulses `chanEnd` and clears `dmaActive`. The next start clears `errFlag`.
- R12: A chunk in the same cycle as `startReq` is dropped, and the start takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Arm a new transfer |
| isOptical | input | 1 | Drive kind at start: 1 optical, 0 disk |
| cmdType | input | 2 | Disk command: 0 read, 1 write, 2 trim, 3 illegal |
| lbaNone | input | 1 | Optical data has no block address |
| sectorNum | input | SECT_W | Starting disk sector or optical LBA |
| sectorCount | input | CNT_W | Disk sector count |
| packetSize | input | LEN_W | Optical transfer size in bytes |
| chunkValid | input | 1 | Channel presents a chunk |
| chunkLen | input | LEN_W | Chunk length in bytes |
| blkDone | input | 1 | Storage completed the pending request |
| blkErr | input | 1 | Completion carries an error |
| reqValid | output | 1 | Block request pulse |
| reqOp | output | 2 | 0 read, 1 write, 2 trim, 3 buffer copy |
| reqOffset | output | OFF_W | Media byte offset |
| reqLen | output | LEN_W | Request length in bytes |
| statusOut | output | 8 | Drive status byte |
| irq | output | 1 | Completion interrupt pulse |
| chanEnd | output | 1 | Channel segment end pulse |
| chanKick | output | 1 | Channel restart pulse after start |
| dmaActive | output | 1 | Transfer armed |
| errFlag | output | 1 | Illegal-command fault |
| acctFail | output | 1 | Failed read/write accounting pulse |

## Verification
Arming and chunk intake can land on the same edge. The bench drives `startReq` and `chunkValid` together, once on a freshly reset sequencer and once after a completed transfer. The result is judged correct when that cycle shows only the kick pulse, with no request and no channel end, and when the next chunk is issued at the bare sector offset, which proves the index was not advanced. Error completion and the good-status path are exercised in separate runs, as are a trim and a read failure, so that the accounting pulse is told apart by command.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_TRIM  = 2'd2,
    OP_COPY  = 2'd3
  } op_e;

  localparam logic [1:0] CMD_ILLEGAL = 2'd3;
  localparam logic [7:0] ST_GOOD = 8'h50;
  localparam logic [7:0] ST_BAD  = 8'h41;

  typedef enum logic [1:0] {
    S_WAIT,
    S_BUSY,
    S_FAULT
  } state_e;

  typedef struct packed {
    logic load;
    logic issue;
    logic copy;
  } strobe_t;

endpackage

// File: rtl/ide_dma_dp.sv
module ide_dma_dp
  import ide_dma_pkg::*;
#(
  parameter int SECT_W = 28,
  parameter int CNT_W  = 9,
  parameter int LEN_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic                   optIn,
  input  logic [1:0]             cmdIn,
  input  logic                   nbIn,
  input  logic [SECT_W-1:0]      sectIn,
  input  logic [CNT_W-1:0]       cntIn,
  input  logic [LEN_W-1:0]       pktIn,
  input  logic [LEN_W-1:0]       chunkLen,
  output logic                   optQ,
  output logic [1:0]             cmdQ,
  output logic                   nbQ,
  output logic                   remEmpty,
  output logic                   reqValid,
  output logic [1:0]             reqOp,
  output logic [SECT_W+11:0]     reqOffset,
  output logic [LEN_W-1:0]       reqLen
);

  localparam int DISK_W = CNT_W + 9;
  localparam int BASE_W = (DISK_W > LEN_W) ? DISK_W : LEN_W;
  localparam int REM_W  = BASE_W + 1;
  localparam int OFF_W  = SECT_W + 12;

  logic signed [REM_W-1:0] remQ;
  logic [REM_W-1:0]        idxQ;
  logic [SECT_W-1:0]       sectQ;
  logic signed [REM_W-1:0] chunkS;
  logic [OFF_W-1:0]        baseOff;
  logic [LEN_W-1:0]        copyLen;

  always_comb begin
    chunkS   = $signed(REM_W'(chunkLen));
    baseOff  = optQ ? (OFF_W'(sectQ) << 11) : (OFF_W'(sectQ) << 9);
    remEmpty = remQ[REM_W-1] || (remQ == '0);
    copyLen  = (remQ < chunkS) ? remQ[LEN_W-1:0] : chunkLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ      <= '0;
      idxQ      <= '0;
      sectQ     <= '0;
      optQ      <= 1'b0;
      cmdQ      <= '0;
      nbQ       <= 1'b0;
      reqValid  <= 1'b0;
      reqOp     <= '0;
      reqOffset <= '0;
      reqLen    <= '0;
    end else begin
      reqValid <= strb.issue | strb.copy;
      if (strb.load) begin
        remQ  <= optIn ? $signed(REM_W'(pktIn)) : $signed(REM_W'(cntIn) << 9);
        idxQ  <= '0;
        sectQ <= sectIn;
        optQ  <= optIn;
        cmdQ  <= cmdIn;
        nbQ   <= nbIn;
      end else if (strb.issue) begin
        reqOffset <= baseOff + OFF_W'(idxQ);
        reqLen    <= chunkLen;
        reqOp     <= optQ ? OP_READ : cmdQ;
        remQ      <= remQ - chunkS;
        idxQ      <= idxQ + REM_W'(chunkLen);
      end else if (strb.copy) begin
        reqOffset <= '0;
        reqLen    <= copyLen;
        reqOp     <= OP_COPY;
      end
    end
  end

endmodule

// File: rtl/ide_dma_ctrl.sv
module ide_dma_ctrl
  import ide_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       chunkValid,
  input  logic       chunkZero,
  input  logic       blkDone,
  input  logic       blkErr,
  input  logic       optQ,
  input  logic [1:0] cmdQ,
  input  logic       nbQ,
  input  logic       remEmpty,
  output strobe_t    strb,
  output logic       dmaActive,
  output logic [7:0] statusOut,
  output logic       irq,
  output logic       chanEnd,
  output logic       chanKick,
  output logic       errFlag,
  output logic       acctFail
);

  state_e     stateQ, stateN;
  logic       activeN, irqN, endN, kickN, errN, failN;
  logic [7:0] statusN;

  always_comb begin
    strb    = '0;
    stateN  = stateQ;
    activeN = dmaActive;
    statusN = statusOut;
    errN    = errFlag;
    irqN    = 1'b0;
    endN    = 1'b0;
    kickN   = 1'b0;
    failN   = 1'b0;
    if (startReq) begin
      strb.load = 1'b1;
      activeN   = 1'b1;
      kickN     = 1'b1;
      errN      = 1'b0;
      stateN    = S_WAIT;
    end else begin
      unique case (stateQ)
        S_WAIT: begin
          if (chunkValid && dmaActive) begin
            if (remEmpty) begin
              statusN = ST_GOOD;
              irqN    = 1'b1;
              endN    = 1'b1;
              activeN = 1'b0;
            end else if (chunkZero) begin
              endN = 1'b1;
            end else if (optQ && nbQ) begin
              strb.copy = 1'b1;
              statusN   = ST_GOOD;
              irqN      = 1'b1;
              endN      = 1'b1;
              activeN   = 1'b0;
            end else if (!optQ && cmdQ == CMD_ILLEGAL) begin
              stateN  = S_FAULT;
              errN    = 1'b1;
              statusN = ST_BAD;
              endN    = 1'b1;
              activeN = 1'b0;
            end else begin
              strb.issue = 1'b1;
              stateN     = S_BUSY;
            end
          end
        end
        S_BUSY: begin
          if (blkDone) begin
            stateN = S_WAIT;
            endN   = 1'b1;
            if (blkErr) begin
              statusN = ST_BAD;
              irqN    = 1'b1;
              activeN = 1'b0;
              failN   = optQ || (cmdQ != OP_TRIM);
            end else if (remEmpty) begin
              statusN = ST_GOOD;
              irqN    = 1'b1;
              activeN = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= S_WAIT;
      dmaActive <= 1'b0;
      statusOut <= 8'h00;
      errFlag   <= 1'b0;
      irq       <= 1'b0;
      chanEnd   <= 1'b0;
      chanKick  <= 1'b0;
      acctFail  <= 1'b0;
    end else begin
      stateQ    <= stateN;
      dmaActive <= activeN;
      statusOut <= statusN;
      errFlag   <= errN;
      irq       <= irqN;
      chanEnd   <= endN;
      chanKick  <= kickN;
      acctFail  <= failN;
    end
  end

endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq
  import ide_dma_pkg::*;
#(
  parameter int SECT_W = 28,
  parameter int CNT_W  = 9,
  parameter int LEN_W  = 16,
  localparam int OFF_W = SECT_W + 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              isOptical,
  input  logic [1:0]        cmdType,
  input  logic              lbaNone,
  input  logic [SECT_W-1:0] sectorNum,
  input  logic [CNT_W-1:0]  sectorCount,
  input  logic [LEN_W-1:0]  packetSize,
  input  logic              chunkValid,
  input  logic [LEN_W-1:0]  chunkLen,
  input  logic              blkDone,
  input  logic              blkErr,
  output logic              reqValid,
  output logic [1:0]        reqOp,
  output logic [OFF_W-1:0]  reqOffset,
  output logic [LEN_W-1:0]  reqLen,
  output logic [7:0]        statusOut,
  output logic              irq,
  output logic              chanEnd,
  output logic              chanKick,
  output logic              dmaActive,
  output logic              errFlag,
  output logic              acctFail
);

  strobe_t    strb;
  logic       optQ, nbQ, remEmpty;
  logic [1:0] cmdQ;

  ide_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chunkValid(chunkValid),
    .chunkZero(chunkLen == '0), .blkDone(blkDone), .blkErr(blkErr),
    .optQ(optQ), .cmdQ(cmdQ), .nbQ(nbQ), .remEmpty(remEmpty), .strb(strb),
    .dmaActive(dmaActive), .statusOut(statusOut), .irq(irq), .chanEnd(chanEnd),
    .chanKick(chanKick), .errFlag(errFlag), .acctFail(acctFail)
  );

  ide_dma_dp #(.SECT_W(SECT_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .optIn(isOptical), .cmdIn(cmdType),
    .nbIn(lbaNone), .sectIn(sectorNum), .cntIn(sectorCount), .pktIn(packetSize),
    .chunkLen(chunkLen), .optQ(optQ), .cmdQ(cmdQ), .nbQ(nbQ), .remEmpty(remEmpty),
    .reqValid(reqValid), .reqOp(reqOp), .reqOffset(reqOffset), .reqLen(reqLen)
  );

endmodule

// File: rtl/ide_dma_seq_chk.sv
module ide_dma_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic       chunkValid,
  input logic       reqValid,
  input logic [7:0] statusOut,
  input logic       irq,
  input logic       chanEnd,
  input logic       chanKick,
  input logic       dmaActive,
  input logic       errFlag,
  input logic       acctFail
);

  a_r3_irq_ends_channel: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (chanEnd && !dmaActive));

  a_r2_idle_chunk_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (chunkValid && !dmaActive && !startReq) |=> (!reqValid && !chanEnd && !irq));

  a_r12_start_wins: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (chanKick && dmaActive && !reqValid && !errFlag));

  a_r11_fault_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (chanEnd && !dmaActive && !irq && !reqValid));

  a_r10_fail_with_irq: assert property (@(posedge clk) disable iff (!rstN)
    acctFail |-> (irq && statusOut == 8'h41));

  a_r8_one_request_per_chunk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

endmodule

bind ide_dma_seq ide_dma_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .chunkValid(chunkValid),
  .reqValid(reqValid), .statusOut(statusOut), .irq(irq), .chanEnd(chanEnd),
  .chanKick(chanKick), .dmaActive(dmaActive), .errFlag(errFlag),
  .acctFail(acctFail)
);

// File: tb/sim_ide_dma_seq.sv
module sim_ide_dma_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, isOptical = 1'b0, lbaNone = 1'b0;
  logic [1:0]  cmdType = '0;
  logic [27:0] sectorNum = '0;
  logic [8:0]  sectorCount = '0;
  logic [15:0] packetSize = '0;
  logic        chunkValid = 1'b0, blkDone = 1'b0, blkErr = 1'b0;
  logic [15:0] chunkLen = '0;
  logic        reqValid, irq, chanEnd, chanKick, dmaActive, errFlag, acctFail;
  logic [1:0]  reqOp;
  logic [39:0] reqOffset;
  logic [15:0] reqLen;
  logic [7:0]  statusOut;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ide_dma_seq u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .isOptical(isOptical),
    .cmdType(cmdType), .lbaNone(lbaNone), .sectorNum(sectorNum),
    .sectorCount(sectorCount), .packetSize(packetSize), .chunkValid(chunkValid),
    .chunkLen(chunkLen), .blkDone(blkDone), .blkErr(blkErr), .reqValid(reqValid),
    .reqOp(reqOp), .reqOffset(reqOffset), .reqLen(reqLen), .statusOut(statusOut),
    .irq(irq), .chanEnd(chanEnd), .chanKick(chanKick), .dmaActive(dmaActive),
    .errFlag(errFlag), .acctFail(acctFail)
  );

  typedef struct {
    string       tag;
    logic        rv;
    logic [1:0]  op;
    logic [39:0] off;
    logic [15:0] len;
    logic        irq, endp, kick, act, err, fail;
    logic [7:0]  st;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // bench model of the requirements
  int          mRem = 0, mIdx = 0;
  bit          mAct = 0, mErr = 0;
  logic [7:0]  mSt = 8'h00;
  bit          cOpt = 0, cNb = 0;
  logic [1:0]  cCmd = '0;
  logic [27:0] cSect = '0;
  logic [8:0]  cCnt = '0;
  logic [15:0] cPkt = '0;

  function automatic exp_t quiet(string tag);
    exp_t e;
    e.tag = tag; e.rv = 0; e.op = '0; e.off = '0; e.len = '0;
    e.irq = 0; e.endp = 0; e.kick = 0; e.fail = 0;
    e.act = mAct; e.err = mErr; e.st = mSt;
    return e;
  endfunction

  task automatic drive(input bit st, input bit ch, input bit dn, input bit er,
                       input logic [15:0] len, input exp_t e);
    @(negedge clk);
    startReq = st; chunkValid = ch; blkDone = dn; blkErr = er; chunkLen = len;
    if (st) begin
      isOptical = cOpt; cmdType = cCmd; lbaNone = cNb;
      sectorNum = cSect; sectorCount = cCnt; packetSize = cPkt;
    end
    q.push_back(e);
  endtask

  task automatic idleT(string tag);
    drive(0, 0, 0, 0, 16'd0, quiet(tag));
  endtask

  task automatic startT(bit opt, logic [1:0] cmd, logic [27:0] sect, logic [8:0] cnt,
                        logic [15:0] pkt, bit nb, bit withChunk, logic [15:0] len,
                        string tag);
    exp_t e;
    cOpt = opt; cCmd = cmd; cSect = sect; cCnt = cnt; cPkt = pkt; cNb = nb;
    mRem = opt ? int'(pkt) : int'(cnt) * 512;
    mIdx = 0; mAct = 1; mErr = 0;
    e = quiet(tag);
    e.kick = 1;
    drive(1, withChunk, 0, 0, len, e);
  endtask

  task automatic chunkT(logic [15:0] len, string tag);
    exp_t e;
    if (!mAct) begin
      e = quiet(tag);
    end else if (mRem <= 0) begin
      mAct = 0; mSt = 8'h50;
      e = quiet(tag); e.irq = 1; e.endp = 1;
    end else if (len == 0) begin
      e = quiet(tag); e.endp = 1;
    end else if (cOpt && cNb) begin
      mAct = 0; mSt = 8'h50;
      e = quiet(tag); e.rv = 1; e.op = 2'd3; e.off = '0;
      e.len = (mRem < int'(len)) ? 16'(mRem) : len;
      e.irq = 1; e.endp = 1;
    end else if (!cOpt && cCmd == 2'd3) begin
      mAct = 0; mErr = 1; mSt = 8'h41;
      e = quiet(tag); e.endp = 1;
    end else begin
      e = quiet(tag); e.rv = 1;
      e.op = cOpt ? 2'd0 : cCmd;
      e.off = (cOpt ? ({12'b0, cSect} << 11) : ({12'b0, cSect} << 9)) + 40'(mIdx);
      e.len = len;
      mRem = mRem - int'(len);
      mIdx = mIdx + int'(len);
    end
    drive(0, 1, 0, 0, len, e);
  endtask

  task automatic doneT(bit er, string tag);
    exp_t e;
    if (er) begin
      mAct = 0; mSt = 8'h41;
      e = quiet(tag); e.irq = 1; e.endp = 1;
      e.fail = cOpt || (cCmd != 2'd2);
    end else if (mRem <= 0) begin
      mAct = 0; mSt = 8'h50;
      e = quiet(tag); e.irq = 1; e.endp = 1;
    end else begin
      e = quiet(tag); e.endp = 1;
    end
    drive(0, 0, 1, er, 16'd0, e);
  endtask

  // monitor: pops expected items and compares after each edge
  initial begin
    exp_t e;
    bit bad;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        bad = (reqValid !== e.rv) || (irq !== e.irq) || (chanEnd !== e.endp) ||
              (chanKick !== e.kick) || (dmaActive !== e.act) || (errFlag !== e.err) ||
              (acctFail !== e.fail) || (statusOut !== e.st);
        if (e.rv)
          bad = bad || (reqOp !== e.op) || (reqOffset !== e.off) || (reqLen !== e.len);
        if (bad) begin
          fails++;
          $display("FAIL %s: got rv=%0b op=%0d off=%h len=%0d irq=%0b end=%0b kick=%0b act=%0b err=%0b fail=%0b st=%h | exp rv=%0b op=%0d off=%h len=%0d irq=%0b end=%0b kick=%0b act=%0b err=%0b fail=%0b st=%h",
                   e.tag, reqValid, reqOp, reqOffset, reqLen, irq, chanEnd, chanKick,
                   dmaActive, errFlag, acctFail, statusOut,
                   e.rv, e.op, e.off, e.len, e.irq, e.endp, e.kick, e.act, e.err,
                   e.fail, e.st);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idleT("R1 reset state");
    chunkT(16'd512, "R2 chunk before start");
    // R12: start and chunk together on a fresh sequencer
    startT(0, 2'd0, 28'h100, 9'd2, 16'd0, 0, 1, 16'd512, "R12 start with chunk");
    chunkT(16'd512, "R12 R5 first read at index zero");
    doneT(0, "R9 partial done");
    chunkT(16'd0, "R4 zero length chunk");
    chunkT(16'd512, "R8 R5 second read offset");
    doneT(0, "R9 R3 final done");
    chunkT(16'd512, "R2 chunk after finish");
    // write
    startT(0, 2'd1, 28'h0ABCDE, 9'd1, 16'd0, 0, 0, 16'd0, "R1 write start");
    chunkT(16'd256, "R5 write first half");
    doneT(0, "R9 write partial");
    chunkT(16'd256, "R8 write second half");
    doneT(0, "R9 write complete");
    // empty transfer: chunk with nothing owed
    startT(0, 2'd0, 28'h7, 9'd0, 16'd0, 0, 0, 16'd0, "R1 zero count start");
    chunkT(16'd100, "R3 chunk with nothing owed");
    // trim error: no accounting fail
    startT(0, 2'd2, 28'h40, 9'd1, 16'd0, 0, 0, 16'd0, "R1 trim start");
    chunkT(16'd512, "R5 trim request");
    doneT(1, "R10 trim error");
    // read error: accounting fail
    startT(0, 2'd0, 28'h41, 9'd1, 16'd0, 0, 0, 16'd0, "R1 read start");
    chunkT(16'd512, "R5 read request");
    doneT(1, "R10 read error");
    // illegal command
    startT(0, 2'd3, 28'h5, 9'd1, 16'd0, 0, 0, 16'd0, "R1 illegal start");
    chunkT(16'd512, "R11 illegal command fault");
    chunkT(16'd512, "R11 R2 chunk in fault");
    startT(0, 2'd0, 28'h9, 9'd1, 16'd0, 0, 0, 16'd0, "R1 R11 start clears fault");
    chunkT(16'd512, "R5 read after fault");
    doneT(0, "R9 read after fault done");
    // optical block reads
    startT(1, 2'd1, 28'h5, 9'd0, 16'd4096, 0, 0, 16'd0, "R1 optical start");
    chunkT(16'd2048, "R6 optical first read");
    doneT(0, "R9 optical partial");
    chunkT(16'd2048, "R6 R8 optical second read");
    doneT(0, "R9 optical complete");
    // optical non-block copies
    startT(1, 2'd0, 28'h0, 9'd0, 16'd100, 1, 0, 16'd0, "R1 copy start short");
    chunkT(16'd300, "R7 copy clipped to remaining");
    startT(1, 2'd0, 28'h0, 9'd0, 16'd500, 1, 0, 16'd0, "R1 copy start long");
    chunkT(16'd200, "R7 copy clipped to chunk");
    // R12 again after a completed transfer, then overshoot
    startT(0, 2'd0, 28'h33, 9'd1, 16'd0, 0, 1, 16'd512, "R12 start with chunk again");
    chunkT(16'd1000, "R12 R8 overshoot chunk at index zero");
    doneT(0, "R8 R9 negative remaining completes");
    idleT("R2 quiet after finish");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule